// File: doc/BRIEF.md
# Power Management Capability Locator

This block finds the power management capability of a PCIe function by walking its configuration-space capability list. After a start pulse it reads the dword that holds the first capability pointer. It then follows the chain of capability headers, one dword read at a time, until it meets the power management ID, reaches a null link, or uses up its hop budget.

Reads go out on a plain request/response port. A one-cycle read strobe carries a dword address, and the responder returns data with a valid flag after any latency. Only one read is in flight at a time. When the walk ends, the block pulses `done_o` and holds the result until the next start. The result is a found flag, the dword address of the matching header, and the 16-bit capabilities field with its decoded sub-fields.

Top module: `cap_walker`

## Requirements
- R1: While reset is held and right after it, `rd_req_o`, `done_o`, `found_o` and `busy_o` are 0, and `cap_addr_o` and `pm_caps_o` are 0.
- R2: When `start_i` is seen with `busy_o` low, the next cycle issues a read of dword 13. The first capability pointer is byte 0 (bits 7:0) of that dword.
- R3: A byte pointer becomes a dword address by dropping its two low bits: read address = pointer[7:2]. This applies to both the first pointer and each header's link field.
- R4: Each header carries its ID in bits 7:0 and its next-header link in bits 15:8. An ID of 0x01 ends the walk with `found_o`=1 and `cap_addr_o` equal to that header's dword address.
- R5: On a match, `pm_caps_o` takes bits 31:16 of the matching header. The decoded outputs are: `version_o` = caps[2:0], `pme_clk_o` = caps[3], `d1_sup_o` = caps[9], `d2_sup_o` = caps[10], `pme_sup_o` = caps[15:11].
- R6: A zero first pointer, or a zero link in a non-matching header, ends the walk with `found_o`=0 and `cap_addr_o`=0. No further read is issued.
- R7: The walk reads at most 48 headers. If the 48th header does not match and has a non-zero link, the walk ends not-found.
- R8: `rd_req_o` is a one-cycle pulse and is not raised again until `rd_valid_i` has returned the data for the previous read.
- R9: `done_o` is a one-cycle pulse. `busy_o` is high from the cycle after an accepted start until `done_o`. A `start_i` seen while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (ignored while busy) |
| rd_req_o | output | 1 | Read strobe, one cycle per read |
| rd_addr_o | output | 6 | Dword address of the read |
| rd_data_i | input | 32 | Read data |
| rd_valid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid pulse |
| found_o | output | 1 | Power management entry located |
| cap_addr_o | output | 6 | Dword address of the located header |
| pm_caps_o | output | 16 | Captured capabilities field |
| version_o | output | 3 | Capability version |
| pme_clk_o | output | 1 | Reference clock needed for wake events |
| d1_sup_o | output | 1 | D1 supported |
| d2_sup_o | output | 1 | D2 supported |
| pme_sup_o | output | 5 | Wake-event support mask per power state |

## Verification
Most wrong internal states show up on the read port at the next strobe. A wrong link decode or dropped address bits put a wrong `rd_addr_o` out one cycle after the response. A lost state makes the responder's read count differ from the chain length by the time `done_o` pulses. A broken hop counter shows only at the end of a looping chain, as a read count other than 49. A capture or decode fault shows on the result outputs in the cycle `done_o` is high. Those outputs are compared against fields sliced from the stored header.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int PTR_W  = 8;
  localparam int ADDR_W = PTR_W - 2;
  localparam int CAPS_W = 16;
  localparam int PME_W  = 5;

  // capability field positions
  localparam int VER_LSB = 0;
  localparam int VER_W   = 3;
  localparam int PME_CLK_BIT = 3;
  localparam int D1_BIT  = 9;
  localparam int D2_BIT  = 10;
  localparam int PME_LSB = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_state_e;
endpackage

// File: rtl/cw_hop_cnt.sv
module cw_hop_cnt #(
  parameter int MAX_HOPS = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_HOPS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  // high while the header being answered is the last one allowed
  assign last_o = (cnt_q == CNT_W'(MAX_HOPS - 1));
endmodule

// File: rtl/cw_pm_decode.sv
module cw_pm_decode
  import cw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic [CAPS_W-1:0] caps_i,
  output logic [CAPS_W-1:0] caps_o,
  output logic [VER_W-1:0]  version_o,
  output logic              pme_clk_o,
  output logic              d1_o,
  output logic              d2_o,
  output logic [PME_W-1:0]  pme_mask_o
);
  logic [CAPS_W-1:0] caps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        caps_q <= '0;
    else if (clear_i)   caps_q <= '0;
    else if (capture_i) caps_q <= caps_i;
  end

  assign caps_o     = caps_q;
  assign version_o  = caps_q[VER_LSB +: VER_W];
  assign pme_clk_o  = caps_q[PME_CLK_BIT];
  assign d1_o       = caps_q[D1_BIT];
  assign d2_o       = caps_q[D2_BIT];
  assign pme_mask_o = caps_q[PME_LSB +: PME_W];
endmodule

// File: rtl/cw_ctrl.sv
module cw_ctrl
  import cw_pkg::*;
#(
  parameter int         PTR_DWORD = 13,
  parameter logic [7:0] PM_ID     = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       rd_data_i,
  input  logic              rd_valid_i,
  input  logic              hop_last_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic              clear_o,
  output logic              hop_inc_o,
  output logic              capture_o
);
  walk_state_e       state_q;
  logic              is_hdr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, found_q;
  logic [ADDR_W-1:0] cap_addr_q;

  logic [PTR_W-1:0]  nxt_ptr;
  logic              accept, id_match, end_walk;

  assign accept   = (state_q == ST_WAIT) && rd_valid_i;
  assign nxt_ptr  = is_hdr_q ? rd_data_i[15:8] : rd_data_i[7:0];
  assign id_match = is_hdr_q && (rd_data_i[7:0] == PM_ID);
  assign end_walk = id_match || (nxt_ptr == '0) || (is_hdr_q && hop_last_i);

  assign clear_o   = (state_q == ST_IDLE) && start_i;
  assign hop_inc_o = accept && is_hdr_q;
  assign capture_o = accept && id_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      is_hdr_q   <= 1'b0;
      addr_q     <= '0;
      done_q     <= 1'b0;
      found_q    <= 1'b0;
      cap_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q    <= ST_REQ;
          addr_q     <= ADDR_W'(PTR_DWORD);
          is_hdr_q   <= 1'b0;
          found_q    <= 1'b0;
          cap_addr_q <= '0;
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (accept) begin
          if (end_walk) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            found_q    <= id_match;
            cap_addr_q <= id_match ? addr_q : '0;
          end else begin
            state_q  <= ST_REQ;
            addr_q   <= nxt_ptr[PTR_W-1:2];
            is_hdr_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o   = (state_q == ST_REQ);
  assign rd_addr_o  = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign found_o    = found_q;
  assign cap_addr_o = cap_addr_q;
endmodule

// File: rtl/cap_walker.sv
module cap_walker
  import cw_pkg::*;
#(
  parameter int         PTR_DWORD = 13,
  parameter logic [7:0] PM_ID     = 8'h01,
  parameter int         MAX_HOPS  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [31:0]       rd_data_i,
  input  logic              rd_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [CAPS_W-1:0] pm_caps_o,
  output logic [VER_W-1:0]  version_o,
  output logic              pme_clk_o,
  output logic              d1_sup_o,
  output logic              d2_sup_o,
  output logic [PME_W-1:0]  pme_sup_o
);
  logic clear, hop_inc, hop_last, capture;

  cw_ctrl #(
    .PTR_DWORD (PTR_DWORD),
    .PM_ID     (PM_ID)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .rd_data_i  (rd_data_i),
    .rd_valid_i (rd_valid_i),
    .hop_last_i (hop_last),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .found_o    (found_o),
    .cap_addr_o (cap_addr_o),
    .clear_o    (clear),
    .hop_inc_o  (hop_inc),
    .capture_o  (capture)
  );

  cw_hop_cnt #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (hop_inc),
    .last_o  (hop_last)
  );

  cw_pm_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .capture_i  (capture),
    .caps_i     (rd_data_i[31:16]),
    .caps_o     (pm_caps_o),
    .version_o  (version_o),
    .pme_clk_o  (pme_clk_o),
    .d1_o       (d1_sup_o),
    .d2_o       (d2_sup_o),
    .pme_mask_o (pme_sup_o)
  );
endmodule

// File: rtl/cap_walker_chk.sv
module cap_walker_chk #(
  parameter int PTR_DWORD = 13,
  parameter int MAX_HOPS  = 48
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       rd_req_o,
  input logic [5:0] rd_addr_o,
  input logic       rd_valid_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       found_o,
  input logic [5:0] cap_addr_o
);
  localparam int RC_W = $clog2(MAX_HOPS + 3);

  logic            pend_q;
  logic [RC_W-1:0] resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (rd_req_o)   pend_q <= 1'b1;
    else if (rd_valid_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   resp_q <= '0;
    else if (start_i && !busy_o)   resp_q <= '0;
    else if (rd_valid_i && busy_o) resp_q <= resp_q + 1'b1;
  end

  a_r2_first_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (rd_req_o && rd_addr_o == 6'(PTR_DWORD)));

  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !rd_req_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r6_no_read_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && !busy_o));

  a_r6_addr_zero_when_missing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (cap_addr_o == '0));

  a_r7_hop_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_q <= RC_W'(MAX_HOPS + 1));
endmodule

bind cap_walker cap_walker_chk #(
  .PTR_DWORD (PTR_DWORD),
  .MAX_HOPS  (MAX_HOPS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .found_o    (found_o),
  .cap_addr_o (cap_addr_o)
);

// File: tb/cap_walker_test.sv
`timescale 1ns/1ps
module cap_walker_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_req_o;
  logic [5:0]  rd_addr_o;
  logic [31:0] rd_data_i = '0;
  logic        rd_valid_i = 1'b0;
  logic        busy_o, done_o, found_o;
  logic [5:0]  cap_addr_o;
  logic [15:0] pm_caps_o;
  logic [2:0]  version_o;
  logic        pme_clk_o, d1_sup_o, d2_sup_o;
  logic [4:0]  pme_sup_o;

  int checks = 0;
  int fails  = 0;
  int reads  = 0;
  int lat    = 1;
  logic [31:0] mem [64];

  always #10 clk_i = ~clk_i;

  cap_walker uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i),
    .busy_o(busy_o), .done_o(done_o), .found_o(found_o),
    .cap_addr_o(cap_addr_o), .pm_caps_o(pm_caps_o),
    .version_o(version_o), .pme_clk_o(pme_clk_o),
    .d1_sup_o(d1_sup_o), .d2_sup_o(d2_sup_o), .pme_sup_o(pme_sup_o)
  );

  // responder: answers each strobe after lat negedges
  initial begin : responder
    int pend;
    logic [5:0] a;
    pend = 0;
    a = '0;
    forever begin
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem[a];
        end
      end
      if (rd_req_o) begin
        a = rd_addr_o;
        pend = lat;
        reads++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  // start a walk and wait for done; returns with done_o visible
  task automatic run(output bit seen);
    reads = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk_i);
    end
  endtask

  task automatic chk_caps(input string req, input logic [15:0] c);
    chk(req, pm_caps_o, c);
    chk(req, version_o, c[2:0]);
    chk(req, pme_clk_o, c[3]);
    chk(req, d1_sup_o, c[9]);
    chk(req, d2_sup_o, c[10]);
    chk(req, pme_sup_o, c[15:11]);
  endtask

  localparam int NV = 4;
  localparam int          V_N    [NV] = '{1, 3, 2, 3};
  localparam logic [7:0]  V_ID0  [NV] = '{8'h01, 8'h05, 8'h05, 8'h10};
  localparam logic [7:0]  V_ID1  [NV] = '{8'h00, 8'h10, 8'h11, 8'h01};
  localparam logic [7:0]  V_ID2  [NV] = '{8'h00, 8'h01, 8'h00, 8'h01};
  localparam logic [15:0] V_CAPS [NV] = '{16'hC603, 16'h7E0A, 16'hFFFF, 16'h0208};
  localparam int          V_LAT  [NV] = '{1, 3, 2, 1};
  localparam bit          V_FND  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [5:0]  V_ADDR [NV] = '{6'h10, 6'h18, 6'h00, 6'h14};
  localparam int          V_RDS  [NV] = '{2, 4, 3, 3};

  initial begin : watchdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    bit seen;
    logic [7:0] ids [3];
    clear_mem();
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 req", rd_req_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 found", found_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 caps", pm_caps_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", {rd_req_o, busy_o, cap_addr_o}, 0);

    // R2 first read address and one-cycle strobe
    clear_mem();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk("R2 strobe", rd_req_o, 1);
    chk("R2 addr", rd_addr_o, 13);
    @(negedge clk_i);
    chk("R8 strobe drops", rd_req_o, 0);
    repeat (4) @(negedge clk_i);

    // vector table: chains at bytes 0x40, 0x50, 0x60 (R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      clear_mem();
      lat = V_LAT[v];
      ids[0] = V_ID0[v]; ids[1] = V_ID1[v]; ids[2] = V_ID2[v];
      mem[13] = 32'hBEEF_3A40;
      for (int k = 0; k < V_N[v]; k++) begin
        logic [7:0] nxt;
        nxt = (k == V_N[v] - 1) ? 8'h00 : 8'(8'h50 + 8'(k * 16));
        mem[16 + 4*k] = {(ids[k] == 8'h01) ? V_CAPS[v] : 16'hA5A5, nxt, ids[k]};
      end
      run(seen);
      chk("R9 done seen", seen, 1);
      chk("R4 found", found_o, V_FND[v]);
      chk("R4 addr", cap_addr_o, V_ADDR[v]);
      chk("R6 read count", reads, V_RDS[v]);
      chk_caps("R5 caps", V_FND[v] ? V_CAPS[v] : 16'h0);
      @(negedge clk_i);
      chk("R9 done pulse", done_o, 0);
      chk("R1 found held", found_o, V_FND[v]);
    end

    // R3 low pointer bits dropped, first pointer and link
    clear_mem();
    lat = 1;
    mem[13] = 32'h0000_0043;
    mem[16] = {16'h0, 8'h5E, 8'h09};
    mem[23] = {16'h1234, 8'h00, 8'h01};
    run(seen);
    chk("R3 found", found_o, 1);
    chk("R3 addr", cap_addr_o, 6'd23);
    chk("R3 caps", pm_caps_o, 16'h1234);

    // R6 zero first pointer
    clear_mem();
    mem[13] = 32'hABCD_EF00;
    run(seen);
    chk("R6 done", seen, 1);
    chk("R6 not found", found_o, 0);
    chk("R6 single read", reads, 1);

    // R7 self-looping chain stops after 48 headers
    clear_mem();
    mem[13] = 32'h0000_0040;
    mem[16] = {16'hFFFF, 8'h40, 8'h05};
    run(seen);
    chk("R7 done", seen, 1);
    chk("R7 not found", found_o, 0);
    chk("R7 reads", reads, 49);
    chk("R7 caps untouched", pm_caps_o, 0);

    // R7 match on the 48th header still found
    clear_mem();
    mem[13] = 32'h0000_0040;
    for (int k = 0; k < 47; k++)
      mem[16 + (k % 2)] = {16'h0, (k % 2 == 0) ? 8'h44 : 8'h40, 8'h07};
    // 48th header read is at dword 17 (odd step); make it loop but flip ID after 47 reads
    mem[16] = {16'h0, 8'h44, 8'h07};
    mem[17] = {16'h0, 8'h40, 8'h07};
    reads = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    wait (reads == 48);
    mem[17] = {16'h4321, 8'h40, 8'h01};
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk_i);
    end
    chk("R7 last allowed match", found_o, 1);
    chk("R7 last addr", cap_addr_o, 6'd17);

    // R9 start while busy is ignored
    clear_mem();
    lat = 3;
    mem[13] = 32'h0000_0040;
    mem[16] = {16'h0, 8'h50, 8'h05};
    mem[20] = {16'h0208, 8'h00, 8'h01};
    reads = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk("R9 busy", busy_o, 1);
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk_i);
    end
    chk("R9 found", found_o, 1);
    chk("R9 addr", cap_addr_o, 6'd20);
    chk("R9 reads", reads, 3);
    repeat (10) @(negedge clk_i);
    chk("R9 no restart", {busy_o, reads[7:0]}, {1'b0, 8'd3});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule